// File: doc/BRIEF.md
# Burst-Four Double-Rate Synchronous SRAM Core

This block models the front end of a pipelined synchronous SRAM that moves two data words per clock cycle. A rising-edge lane and a falling-edge lane run side by side, so each cycle carries two beats. One command is sampled at the rising edge of `clk`. It is either a read or a write, and it always moves a burst of four words that lie inside one aligned four-word block of a small internal array. A two-bit burst counter starts at the low two address bits and steps modulo four. Because of this, a burst that starts inside a block wraps to the start of that same block.

A write is held in a set of pending registers once its four words are in. It moves into the array when the next write completes. A read of the block that is still pending returns the new words from those registers. A deselect input blocks new commands. It does not cut short a write that has already been accepted.

Top module: `ddr4b_sram`

## Requirements
- R1: A command is accepted at a rising edge when `strobe_n` is low, `desel` is low and no burst is in its second cycle. With `is_read` high, `rd_valid` is high for exactly the two following cycles, unless a new read is accepted right after. The first of these cycles carries burst words 0 and 1, and the second carries words 2 and 3.
- R2: An accepted command with `is_read` low is a write. The accept cycle supplies burst words 0 and 1 on `wd_rise` and `wd_fall`. The next cycle supplies words 2 and 3 on the same lanes. A later read returns these four words.
- R3: Burst word j maps to array word {addr[AW-1:2], (addr[1:0]+j) mod 4}. Even-numbered words travel on the rise lane and odd-numbered words on the fall lane. A burst started at offset 2'b01 therefore visits offsets 01, 10, 11, 00.
- R4: A low `strobe_n` (with `desel` low) in the second cycle of a burst is ignored. It does not write, read or extend the burst. `proto_err` is high in the following cycle, and only then.
- R5: A read of the block whose write is still held in the pending registers returns that write's words in burst order. This includes a read accepted on the first cycle allowed after the write.
- R6: A command presented while `desel` is high and no burst is running is ignored. There is no `rd_valid`, no `proto_err` and no change to stored data.
- R7: A write already accepted completes its second data cycle even if `desel` is high in that cycle.
- R8: Reset is synchronous and active high. It clears the burst state and the pending-write valid flag, and it drives `rd_valid` and `proto_err` low. Whenever `rd_valid` is low, `rd_rise` and `rd_fall` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Active-low command load strobe |
| is_read | input | 1 | High selects read, low selects write |
| desel | input | 1 | High blocks acceptance of new commands |
| addr | input | AW | Word address; low two bits are the burst start offset |
| wd_rise | input | DW | Write data, even burst words |
| wd_fall | input | DW | Write data, odd burst words |
| rd_rise | output | DW | Read data, even burst words |
| rd_fall | output | DW | Read data, odd burst words |
| rd_valid | output | 1 | High while read lanes carry burst data |
| proto_err | output | 1 | One-cycle flag for a strobe that overlaps a burst |

## Verification
The bench builds the block with its defaults: AW = 8, which gives 256 words in 64 blocks, and DW = 36. With these values the top block (addresses 0xFC to 0xFF) can be reached, and a wrapping burst there shows that the offset wraps inside its block instead of carrying into the block index. The 36-bit words are built from a seed and the word position, so a swapped lane or a wrong offset shows up as a value mismatch. Write-then-read pairs to the same block make the pending-register path, and its later move into the array, visible at the read lanes.

// File: rtl/ddr4b_pkg.sv
package ddr4b_pkg;
   localparam int unsigned BURST_WORDS = 4;
   localparam int unsigned OFF_W       = 2;
   typedef logic [OFF_W-1:0] boff_t;
endpackage

// File: rtl/ddr4b_burst_ctr.sv
module ddr4b_burst_ctr
   import ddr4b_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  load,
   input  boff_t start,
   output boff_t pair_lo,
   output boff_t pair_hi
);
   boff_t nxt_q;

   // first beat pair uses the loaded offset directly, the second the stored step
   assign pair_lo = load ? start : nxt_q;
   assign pair_hi = pair_lo + boff_t'(1);

   always_ff @(posedge clk) begin
      if (rst)       nxt_q <= '0;
      else if (load) nxt_q <= start + boff_t'(2);
   end
endmodule

// File: rtl/ddr4b_wr_regs.sv
module ddr4b_wr_regs
   import ddr4b_pkg::*;
#(
   parameter int DW = 36,
   parameter int BW = 6
)(
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             cap_first,
   input  logic                             cap_last,
   input  boff_t                            pair_lo,
   input  boff_t                            pair_hi,
   input  logic [DW-1:0]                    lane_r,
   input  logic [DW-1:0]                    lane_f,
   input  logic [BW-1:0]                    base_in,
   output logic                             pend_vld,
   output logic [BW-1:0]                    pend_base,
   output logic [BURST_WORDS-1:0][DW-1:0]   pend_data,
   output logic                             commit_en
);
   logic [BURST_WORDS-1:0][DW-1:0] stage_q;

   // an older pending burst retires into the array as a newer one lands
   assign commit_en = cap_last & pend_vld;

   always_ff @(posedge clk) begin
      if (cap_first) begin
         stage_q[pair_lo] <= lane_r;
         stage_q[pair_hi] <= lane_f;
      end
   end

   always_ff @(posedge clk) begin
      if (cap_last) begin
         for (int i = 0; i < BURST_WORDS; i++) begin
            if (boff_t'(i) == pair_lo)      pend_data[i] <= lane_r;
            else if (boff_t'(i) == pair_hi) pend_data[i] <= lane_f;
            else                            pend_data[i] <= stage_q[i];
         end
         pend_base <= base_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)           pend_vld <= 1'b0;
      else if (cap_last) pend_vld <= 1'b1;
   end
endmodule

// File: rtl/ddr4b_array.sv
module ddr4b_array
   import ddr4b_pkg::*;
#(
   parameter int DW = 36,
   parameter int AW = 8
)(
   input  logic                           clk,
   input  logic                           we,
   input  logic [AW-OFF_W-1:0]            wbase,
   input  logic [BURST_WORDS-1:0][DW-1:0] wdata,
   input  logic [AW-OFF_W-1:0]            rbase,
   input  boff_t                          roff_a,
   input  boff_t                          roff_b,
   output logic [DW-1:0]                  rword_a,
   output logic [DW-1:0]                  rword_b
);
   localparam int DEPTH = 1 << AW;

   generate
      if (DEPTH > 4096) begin : g_depth_chk
         $error("ddr4b_array: AW gives a model array that is too large");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < BURST_WORDS; i++) begin
            mem[{wbase, boff_t'(i)}] <= wdata[i];
         end
      end
   end

   assign rword_a = mem[{rbase, roff_a}];
   assign rword_b = mem[{rbase, roff_b}];
endmodule

// File: rtl/ddr4b_sram.sv
module ddr4b_sram
   import ddr4b_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 36
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          strobe_n,
   input  logic          is_read,
   input  logic          desel,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd_rise,
   input  logic [DW-1:0] wd_fall,
   output logic [DW-1:0] rd_rise,
   output logic [DW-1:0] rd_fall,
   output logic          rd_valid,
   output logic          proto_err
);
   localparam int BW = AW - OFF_W;

   generate
      if (AW < OFF_W + 1) begin : g_aw_chk
         $error("ddr4b_sram: AW must leave at least one block index bit");
      end
      if (DW < 1) begin : g_dw_chk
         $error("ddr4b_sram: DW must be positive");
      end
   endgenerate

   logic          busy_q;
   logic          op_rd_q;
   logic [BW-1:0] base_q;
   logic          accept, acc_rd, acc_wr, second_rd, second_wr;
   logic [BW-1:0] cur_base;
   boff_t         pair_lo, pair_hi;

   logic                           pend_vld, commit_en;
   logic [BW-1:0]                  pend_base;
   logic [BURST_WORDS-1:0][DW-1:0] pend_data;
   logic [DW-1:0]                  arr_a, arr_b, word_a, word_b;
   logic                           hit;

   // a command is only taken in a cycle where no burst is finishing
   assign accept    = ~strobe_n & ~desel & ~busy_q;
   assign acc_rd    = accept & is_read;
   assign acc_wr    = accept & ~is_read;
   assign second_rd = busy_q & op_rd_q;
   assign second_wr = busy_q & ~op_rd_q;
   assign cur_base  = busy_q ? base_q : addr[AW-1:OFF_W];

   always_ff @(posedge clk) begin
      if (rst) busy_q <= 1'b0;
      else     busy_q <= accept;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         op_rd_q <= is_read;
         base_q  <= addr[AW-1:OFF_W];
      end
   end

   ddr4b_burst_ctr u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .start   (addr[OFF_W-1:0]),
      .pair_lo (pair_lo),
      .pair_hi (pair_hi)
   );

   ddr4b_wr_regs #(.DW(DW), .BW(BW)) u_wr (
      .clk       (clk),
      .rst       (rst),
      .cap_first (acc_wr),
      .cap_last  (second_wr),
      .pair_lo   (pair_lo),
      .pair_hi   (pair_hi),
      .lane_r    (wd_rise),
      .lane_f    (wd_fall),
      .base_in   (base_q),
      .pend_vld  (pend_vld),
      .pend_base (pend_base),
      .pend_data (pend_data),
      .commit_en (commit_en)
   );

   ddr4b_array #(.DW(DW), .AW(AW)) u_arr (
      .clk     (clk),
      .we      (commit_en),
      .wbase   (pend_base),
      .wdata   (pend_data),
      .rbase   (cur_base),
      .roff_a  (pair_lo),
      .roff_b  (pair_hi),
      .rword_a (arr_a),
      .rword_b (arr_b)
   );

   // a read of the still-pending block is served from the write registers
   assign hit    = pend_vld & (pend_base == cur_base);
   assign word_a = hit ? pend_data[pair_lo] : arr_a;
   assign word_b = hit ? pend_data[pair_hi] : arr_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_rise  <= '0;
         rd_fall  <= '0;
         rd_valid <= 1'b0;
      end else if (acc_rd | second_rd) begin
         rd_rise  <= word_a;
         rd_fall  <= word_b;
         rd_valid <= 1'b1;
      end else begin
         rd_rise  <= '0;
         rd_fall  <= '0;
         rd_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) proto_err <= 1'b0;
      else     proto_err <= ~strobe_n & ~desel & busy_q;
   end
endmodule

// File: rtl/ddr4b_sram_chk.sv
module ddr4b_sram_chk #(
   parameter int DW = 36
)(
   input logic          clk,
   input logic          rst,
   input logic          strobe_n,
   input logic          desel,
   input logic          busy,
   input logic          rd_valid,
   input logic          proto_err,
   input logic [DW-1:0] rd_rise,
   input logic [DW-1:0] rd_fall
);
   p_two_beats_r1: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !$past(rd_valid)) |=> rd_valid);

   p_busy_single_r4: assert property (@(posedge clk) disable iff (rst)
      busy |=> !busy);

   p_overlap_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (!strobe_n && !desel && busy) |=> proto_err);

   p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
      (strobe_n || desel || !busy) |=> !proto_err);

   p_desel_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      (desel && !busy) |=> !rd_valid);

   p_idle_lanes_r8: assert property (@(posedge clk) disable iff (rst)
      !rd_valid |-> (rd_rise == '0 && rd_fall == '0));
endmodule

bind ddr4b_sram ddr4b_sram_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .strobe_n  (strobe_n),
   .desel     (desel),
   .busy      (busy_q),
   .rd_valid  (rd_valid),
   .proto_err (proto_err),
   .rd_rise   (rd_rise),
   .rd_fall   (rd_fall)
);

// File: tb/tb_ddr4b_sram.sv
module tb_ddr4b_sram;
   localparam int AW = 8;
   localparam int DW = 36;
   localparam int NV = 13;

   // {is_read, addr, seed}
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 8'h05, 8'h11}, {1'b1, 8'h04, 8'h00}, {1'b1, 8'h07, 8'h00},
      {1'b0, 8'h12, 8'h22}, {1'b1, 8'h05, 8'h00}, {1'b1, 8'h13, 8'h00},
      {1'b0, 8'hFE, 8'h33}, {1'b1, 8'hFC, 8'h00}, {1'b0, 8'h12, 8'h44},
      {1'b1, 8'h11, 8'h00}, {1'b1, 8'h06, 8'h00}, {1'b0, 8'h2B, 8'h55},
      {1'b1, 8'h2A, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          strobe_n = 1'b1;
   logic          is_read = 1'b0;
   logic          desel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wd_rise = '0;
   logic [DW-1:0] wd_fall = '0;
   logic [DW-1:0] rd_rise, rd_fall;
   logic          rd_valid, proto_err;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [DW-1:0] ref_mem [1 << AW];

   always #10 clk = ~clk;

   ddr4b_sram #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst(rst), .strobe_n(strobe_n), .is_read(is_read),
      .desel(desel), .addr(addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
      .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_valid(rd_valid),
      .proto_err(proto_err)
   );

   function automatic logic [DW-1:0] wdat(input logic [7:0] s, input int j);
      return {4'h9, s, 8'(j), ~s, 8'hC3};
   endfunction

   function automatic logic [AW-1:0] waddr(input logic [AW-1:0] a, input int j);
      return {a[AW-1:2], 2'(a[1:0] + 2'(j))};
   endfunction

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // one command, two cycles; reads compared word by word against ref_mem
   task automatic run_op(input logic rd, input logic [AW-1:0] a, input logic [7:0] s);
      strobe_n = 1'b0; is_read = rd; addr = a;
      wd_rise = rd ? '0 : wdat(s, 0);
      wd_fall = rd ? '0 : wdat(s, 1);
      if (!rd) for (int j = 0; j < 4; j++) ref_mem[waddr(a, j)] = wdat(s, j);
      tick();
      strobe_n = 1'b1;
      wd_rise = rd ? '0 : wdat(s, 2);
      wd_fall = rd ? '0 : wdat(s, 3);
      if (rd) begin
         chk("R1 valid beat0", DW'(rd_valid), DW'(1));
         chk("R3/R5 word0 rise", rd_rise, ref_mem[waddr(a, 0)]);
         chk("R3/R5 word1 fall", rd_fall, ref_mem[waddr(a, 1)]);
      end
      tick();
      wd_rise = '0; wd_fall = '0;
      if (rd) begin
         chk("R1 valid beat1", DW'(rd_valid), DW'(1));
         chk("R2/R3 word2 rise", rd_rise, ref_mem[waddr(a, 2)]);
         chk("R2/R3 word3 fall", rd_fall, ref_mem[waddr(a, 3)]);
      end
   endtask

   initial begin
      repeat (4) tick();
      chk("R8 reset valid", DW'(rd_valid), DW'(0));
      chk("R8 reset err", DW'(proto_err), DW'(0));
      rst = 1'b0;
      tick();
      chk("R8 idle rise", rd_rise, '0);

      for (int i = 0; i < NV; i++) run_op(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      tick();
      chk("R1 valid drops", DW'(rd_valid), DW'(0));

      // R4: strobe in second read cycle trying a write to block 0x10
      strobe_n = 1'b0; is_read = 1'b1; addr = 8'h04;
      tick();
      is_read = 1'b0; addr = 8'h10; wd_rise = '1; wd_fall = '1;
      tick();
      chk("R4 err raised", DW'(proto_err), DW'(1));
      chk("R4 burst still valid", DW'(rd_valid), DW'(1));
      strobe_n = 1'b1; wd_rise = '0; wd_fall = '0;
      tick();
      chk("R4 err one cycle", DW'(proto_err), DW'(0));
      chk("R4 no extra beat", DW'(rd_valid), DW'(0));
      run_op(1'b1, 8'h10, 8'h00);

      // R6: deselected read and write are ignored
      desel = 1'b1; strobe_n = 1'b0; is_read = 1'b1; addr = 8'h04;
      tick();
      chk("R6 no valid", DW'(rd_valid), DW'(0));
      chk("R6 no err", DW'(proto_err), DW'(0));
      chk("R8 idle lanes zero", rd_fall, '0);
      is_read = 1'b0; addr = 8'h2A; wd_rise = '1; wd_fall = '1;
      tick();
      tick();
      chk("R6 still no err", DW'(proto_err), DW'(0));
      desel = 1'b0; strobe_n = 1'b1; wd_rise = '0; wd_fall = '0;
      tick();
      run_op(1'b1, 8'h28, 8'h00);

      // R7: deselect rises during the second write cycle
      strobe_n = 1'b0; is_read = 1'b0; addr = 8'h31;
      wd_rise = wdat(8'h66, 0); wd_fall = wdat(8'h66, 1);
      for (int j = 0; j < 4; j++) ref_mem[waddr(8'h31, j)] = wdat(8'h66, j);
      tick();
      desel = 1'b1; addr = 8'h04; is_read = 1'b1;
      wd_rise = wdat(8'h66, 2); wd_fall = wdat(8'h66, 3);
      tick();
      chk("R7 no read started", DW'(rd_valid), DW'(0));
      desel = 1'b0; strobe_n = 1'b1; wd_rise = '0; wd_fall = '0;
      tick();
      run_op(1'b1, 8'h30, 8'h00);
      run_op(1'b0, 8'h40, 8'h77);
      run_op(1'b1, 8'h33, 8'h00);
      run_op(1'b1, 8'h42, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule